// File: doc/BRIEF.md
# Timebase and Tone Generator

This peripheral sits on a byte-wide register bus and is clocked by a single input clock of nominally 8 MHz. It holds two 8-bit registers. The control/status register carries a periodic timebase selection, an interrupt enable, a few stored system-clock control bits and a read-only elapsed flag. The tone register selects a square-wave tone that drives one output pin.

The timebase counter runs continuously. Each time it reaches the selected period it sets the elapsed flag. The interrupt line is asserted while both the flag and the enable are set. Software acknowledges the event by reading the control/status register, and that read clears the flag. Writes never touch the flag, so a read-modify-write sequence cannot discard a pending event.

The tone divider toggles the output pin at a rate chosen by a two-bit code, which gives a 50% duty square wave. The pin is held low when the tone is off. The divider restarts cleanly whenever the code changes.

Top module: `tick_tone_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq_o` is low and `beep_o` is low.
- R2: A write to the control/status register (address 0x2C) stores bits 7:1. Bit 7 is the clock-out enable, bits 6:5 the prescaler, bit 4 the slow select, bits 3:2 the period select and bit 1 the interrupt enable. All of them read back unchanged. Write data bit 0 has no effect on the flag.
- R3: Period select codes 00, 01, 10 and 11 choose PERIOD0..PERIOD3 clocks (defaults 16000, 32000, 80000, 200000). The flag (bit 0) becomes 1 exactly that many clocks after the last control/status write or after reset, and the event then repeats at that interval.
- R4: Every write to the control/status register restarts the timebase count from zero.
- R5: A read of the control/status register returns the current flag and clears it on the following clock edge. Nothing else clears it.
- R6: If a timebase event coincides with a control/status read, that read returns the value from before the event and the flag ends at 1.
- R7: `irq_o` is high exactly when the flag and the interrupt enable (bit 1) are both 1.
- R8: The tone register (address 0x2D) stores bits 1:0. Bits 7:2 always read 0 and ignore writes. A read of an address that is not mapped returns 0x00.
- R9: Tone code 00 holds `beep_o` low. Code 01 toggles it every HALF1 clocks, code 10 every HALF2 and code 11 every HALF3 (defaults 2000, 4000, 8000: about 2 kHz, 1 kHz and 500 Hz at 8 MHz).
- R10: A tone write that changes the code drives `beep_o` low and restarts its half-period count. A write of the same code leaves the waveform undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock (nominally 8 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_en_i` |
| irq_o | output | 1 | Timebase interrupt request |
| beep_o | output | 1 | Square-wave tone output |

## Verification
The timebase is tried with each of the four period codes and with idle runs long enough to see several events. This separates an off-by-one period from a wrong code mapping. A write in the middle of a count shows whether the count restarts. A read placed exactly on the event cycle and reads placed away from it show whether the set takes priority over the clear. The tone output is driven through all three tone codes, a same-code rewrite and a code change in mid-waveform, which separates wrong divide ratios from spurious restarts.

// File: rtl/tick_tone_pkg.sv
package tick_tone_pkg;

  typedef enum logic [1:0] {
    TONE_OFF = 2'b00,
    TONE_HI  = 2'b01,
    TONE_MID = 2'b10,
    TONE_LO  = 2'b11
  } tone_code_e;

  // stored control bits of the control/status register, bits 7:1
  typedef struct packed {
    logic       clk_out_en;
    logic [1:0] presc;
    logic       slow_sel;
    logic [1:0] period_sel;
    logic       irq_en;
  } ctl_bits_t;

endpackage

// File: rtl/tt_timebase.sv
module tt_timebase #(
  parameter int unsigned PERIOD0 = 16000,
  parameter int unsigned PERIOD1 = 32000,
  parameter int unsigned PERIOD2 = 80000,
  parameter int unsigned PERIOD3 = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  localparam int unsigned PMAX_A = (PERIOD0 > PERIOD1) ? PERIOD0 : PERIOD1;
  localparam int unsigned PMAX_B = (PERIOD2 > PERIOD3) ? PERIOD2 : PERIOD3;
  localparam int unsigned PMAX   = (PMAX_A > PMAX_B) ? PMAX_A : PMAX_B;
  localparam int unsigned CNT_W  = (PMAX > 2) ? $clog2(PMAX) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             wrap;

  always_comb begin
    case (sel_i)
      2'd0:    last = CNT_W'(PERIOD0 - 1);
      2'd1:    last = CNT_W'(PERIOD1 - 1);
      2'd2:    last = CNT_W'(PERIOD2 - 1);
      default: last = CNT_W'(PERIOD3 - 1);
    endcase
  end

  assign wrap   = (cnt_q == last);
  assign tick_o = wrap && !restart_i;

  always_comb begin
    if (restart_i || wrap) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tt_tone_div.sv
module tt_tone_div
  import tick_tone_pkg::*;
#(
  parameter int unsigned HALF1 = 2000,
  parameter int unsigned HALF2 = 4000,
  parameter int unsigned HALF3 = 8000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  input  logic       restart_i,
  output logic       beep_o
);

  localparam int unsigned HMAX_A = (HALF1 > HALF2) ? HALF1 : HALF2;
  localparam int unsigned HMAX   = (HMAX_A > HALF3) ? HMAX_A : HALF3;
  localparam int unsigned CNT_W  = (HMAX > 2) ? $clog2(HMAX) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             lvl_q, lvl_d;
  logic             off;

  assign off = (tone_code_e'(code_i) == TONE_OFF);

  always_comb begin
    case (tone_code_e'(code_i))
      TONE_HI:  last = CNT_W'(HALF1 - 1);
      TONE_MID: last = CNT_W'(HALF2 - 1);
      default:  last = CNT_W'(HALF3 - 1);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    lvl_d = lvl_q;
    if (restart_i || off) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (cnt_q == last) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign beep_o = lvl_q;

endmodule

// File: rtl/tick_tone_ctrl.sv
module tick_tone_ctrl
  import tick_tone_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = ADDR_W'(8'h2C),
  parameter logic [ADDR_W-1:0] TONE_ADDR = ADDR_W'(8'h2D),
  parameter int unsigned PERIOD0   = 16000,
  parameter int unsigned PERIOD1   = 32000,
  parameter int unsigned PERIOD2   = 80000,
  parameter int unsigned PERIOD3   = 200000,
  parameter int unsigned HALF1     = 2000,
  parameter int unsigned HALF2     = 4000,
  parameter int unsigned HALF3     = 8000,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  output logic              beep_o
);

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[RST_STAGES-1];

  // register state
  ctl_bits_t  ctl_q, ctl_d;
  logic       flag_q, flag_d;
  logic [1:0] code_q, code_d;

  logic csr_we, csr_re, tone_we, tone_chg, tick;

  assign csr_we   = wr_en_i && (addr_i == CSR_ADDR);
  assign csr_re   = rd_en_i && (addr_i == CSR_ADDR);
  assign tone_we  = wr_en_i && (addr_i == TONE_ADDR);
  assign tone_chg = tone_we && (wdata_i[1:0] != code_q);

  // next state
  always_comb begin
    ctl_d  = ctl_q;
    code_d = code_q;
    if (csr_we)  ctl_d  = ctl_bits_t'(wdata_i[7:1]);
    if (tone_we) code_d = wdata_i[1:0];
    if (tick)        flag_d = 1'b1;   // a coinciding read loses
    else if (csr_re) flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
      code_q <= 2'b00;
    end else begin
      if (csr_we)  ctl_q  <= ctl_d;
      if (tone_we) code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = 8'h00;
    if (rd_en_i) begin
      if (addr_i == CSR_ADDR)       rdata_o = {ctl_q, flag_q};
      else if (addr_i == TONE_ADDR) rdata_o = {6'b000000, code_q};
    end
  end

  assign irq_o = flag_q & ctl_q.irq_en;

  tt_timebase #(
    .PERIOD0(PERIOD0), .PERIOD1(PERIOD1), .PERIOD2(PERIOD2), .PERIOD3(PERIOD3)
  ) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .restart_i(csr_we),
    .sel_i    (ctl_q.period_sel),
    .tick_o   (tick)
  );

  tt_tone_div #(
    .HALF1(HALF1), .HALF2(HALF2), .HALF3(HALF3)
  ) u_tone (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .code_i   (code_q),
    .restart_i(tone_chg),
    .beep_o   (beep_o)
  );

endmodule

// File: rtl/tick_tone_chk.sv
module tick_tone_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = ADDR_W'(8'h2C),
  parameter logic [ADDR_W-1:0] TONE_ADDR = ADDR_W'(8'h2D)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_i,
  input logic              irq_i,
  input logic              beep_i,
  input logic              flag_i,
  input logic              ie_i,
  input logic              tick_i,
  input logic [1:0]        code_i
);

  logic rd_csr, tone_new;
  assign rd_csr   = rd_en_i && (addr_i == CSR_ADDR);
  assign tone_new = wr_en_i && (addr_i == TONE_ADDR) && (wdata_i[1:0] != code_i);

  p_flag_from_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(tick_i));

  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !rd_csr) |=> flag_i);

  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_csr && !tick_i) |=> !flag_i);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_csr && tick_i) |=> flag_i);

  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ie_i && flag_i));

  p_tone_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == TONE_ADDR) |-> (rdata_i[7:2] == 6'b000000));

  p_off_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 2'b00 && !tone_new) |=> !beep_i);

  p_change_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_new |=> !beep_i);

endmodule

bind tick_tone_ctrl tick_tone_chk #(
  .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .TONE_ADDR(TONE_ADDR)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_n),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_i(rdata_o),
  .irq_i  (irq_o),
  .beep_i (beep_o),
  .flag_i (flag_q),
  .ie_i   (ctl_q.irq_en),
  .tick_i (tick),
  .code_i (code_q)
);

// File: tb/tick_tone_ctrl_tb_top.sv
`timescale 1ns/1ps
module tick_tone_ctrl_tb_top;

  localparam int P0 = 20, P1 = 30, P2 = 50, P3 = 70;
  localparam int H1 = 3,  H2 = 5,  H3 = 8;
  localparam logic [7:0] A_CSR = 8'h2C, A_TONE = 8'h2D;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [7:0] addr, wdata, rdata;
  logic       irq, beep;

  always #2.5 clk = ~clk;

  tick_tone_ctrl #(
    .ADDR_W(8), .CSR_ADDR(A_CSR), .TONE_ADDR(A_TONE),
    .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2), .PERIOD3(P3),
    .HALF1(H1), .HALF2(H2), .HALF3(H3), .RST_STAGES(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .beep_o(beep)
  );

  // behavioural reference state
  logic [6:0] m_ctl;
  logic       m_flag;
  logic [1:0] m_code;
  int         m_tcnt, m_bcnt;
  logic       m_beep;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int period_of(input logic [1:0] s);
    case (s)
      2'd0: return P0;
      2'd1: return P1;
      2'd2: return P2;
      default: return P3;
    endcase
  endfunction

  function automatic int half_of(input logic [1:0] c);
    case (c)
      2'd1: return H1;
      2'd2: return H2;
      default: return H3;
    endcase
  endfunction

  // one bus cycle: drive, compare against the model, advance the model
  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] exp_rd;
    bit         w_csr, r_csr, w_tone, ev;
    int         n_tcnt, n_bcnt;
    logic       n_flag, n_beep;
    logic [6:0] n_ctl;
    logic [1:0] n_code;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    #1;
    exp_rd = 8'h00;
    if (rd && a == A_CSR)  exp_rd = {m_ctl, m_flag};
    if (rd && a == A_TONE) exp_rd = {6'b0, m_code};
    chk("rdata", rdata, exp_rd);
    chk("irq", {7'b0, irq}, {7'b0, m_flag & m_ctl[0]});
    chk("beep", {7'b0, beep}, {7'b0, m_beep});
    w_csr  = wr && a == A_CSR;
    r_csr  = rd && a == A_CSR;
    w_tone = wr && a == A_TONE;
    ev     = !w_csr && (m_tcnt == period_of(m_ctl[2:1]) - 1);
    n_tcnt = (w_csr || ev) ? 0 : m_tcnt + 1;
    n_flag = ev ? 1'b1 : (r_csr ? 1'b0 : m_flag);
    n_ctl  = w_csr ? d[7:1] : m_ctl;
    n_code = w_tone ? d[1:0] : m_code;
    n_bcnt = m_bcnt + 1;
    n_beep = m_beep;
    if ((w_tone && d[1:0] != m_code) || m_code == 2'b00) begin
      n_bcnt = 0; n_beep = 1'b0;
    end else if (m_bcnt == half_of(m_code) - 1) begin
      n_bcnt = 0; n_beep = ~m_beep;
    end
    @(posedge clk);
    m_tcnt = n_tcnt; m_flag = n_flag; m_ctl = n_ctl;
    m_code = n_code; m_bcnt = n_bcnt; m_beep = n_beep;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    m_ctl = '0; m_flag = 0; m_code = 0; m_tcnt = 0; m_bcnt = 0; m_beep = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    cur_req = "R1";  cyc(0, 1, A_CSR, 0); cyc(0, 1, A_TONE, 0); idle(2);
    cur_req = "R3";  idle(20); cyc(0, 1, A_CSR, 0); cyc(0, 1, A_CSR, 0);
    cur_req = "R2";  cyc(1, 0, A_CSR, 8'hF7); cyc(0, 1, A_CSR, 0);
                     cyc(1, 0, A_CSR, 8'h01); cyc(0, 1, A_CSR, 0);
    cur_req = "R7";  cyc(1, 0, A_CSR, 8'h06); idle(32); cyc(0, 1, A_CSR, 0); idle(3);
    cur_req = "R3";  cyc(1, 0, A_CSR, 8'h0A); idle(52); cyc(0, 1, A_CSR, 0);
                     cyc(1, 0, A_CSR, 8'h0E); idle(72); cyc(0, 1, A_CSR, 0); idle(75);
    cur_req = "R4";  cyc(1, 0, A_CSR, 8'h02); idle(10); cyc(1, 0, A_CSR, 8'h02);
                     idle(15); cyc(0, 1, A_CSR, 0); idle(6); cyc(0, 1, A_CSR, 0);
    cur_req = "R6";  cyc(1, 0, A_CSR, 8'h02); idle(19); cyc(0, 1, A_CSR, 0);
                     cyc(0, 1, A_CSR, 0);
    cur_req = "R5";  idle(25); cyc(0, 1, A_CSR, 0); idle(2); cyc(0, 1, A_CSR, 0);
    cur_req = "R8";  cyc(1, 0, A_TONE, 8'hFC); cyc(0, 1, A_TONE, 0);
                     cyc(0, 1, 8'h2E, 0); cyc(1, 0, A_TONE, 8'h00); cyc(0, 1, A_TONE, 0);
    cur_req = "R9";  cyc(1, 0, A_TONE, 8'h01); idle(20); cyc(1, 0, A_TONE, 8'h02);
                     idle(30); cyc(1, 0, A_TONE, 8'h03); idle(40);
    cur_req = "R10"; idle(3); cyc(1, 0, A_TONE, 8'h03); idle(10);
                     cyc(1, 0, A_TONE, 8'h01); idle(10); cyc(1, 0, A_TONE, 8'h00); idle(5);
    done = 1;
    finish_run();
  end

endmodule